// File: doc/BRIEF.md
# Watchdog and Wake Stabilization Timer

This block has one 8-bit up-counter that does two jobs. A prescaler divides the oscillator clock and drives the counter. The prescaler's ratio comes from a control byte that software writes. In normal running the counter acts as a watchdog. If software does not clear the counter before it wraps from all ones to zero, the block sends out a one-cycle reset request. Software can turn the request path off by writing a 4-bit disable key into the upper nibble of the control byte.

The same counter also times the oscillator settling period. This happens after power-on and after a wake from Stop mode. While the period runs, the CPU clock enable stays low. It goes high once the counter's top bit is set, and the counter is then zeroed. After power-on the counter always runs at the slowest ratio. After an interrupt wake it runs at the ratio already held in the control byte. While the chip is stopped, the counter and the prescaler hold their values.

Top module: `wdt_stab_timer`

## Requirements
- R1: After `por_n` is released, the control byte reads 8'h00, `rst_req` is 0 and `cpu_clk_en` is 0.
- R2: `ctl_rdata` returns bits [7:2] as last written. Bits [1:0] always read 0.
- R3: Control bits [3:2] select the prescaler ratio. 00 gives 2^LOG_D0, 01 gives 2^LOG_D1, 10 gives 2^LOG_D2 and 11 gives 2^LOG_D3. The defaults are 4096, 1024, 128 and 16.
- R4: A write with bit 1 set zeroes the counter on that edge. Bit 1 is a strobe and is not stored.
- R5: In running state, the counter wraps from 8'hFF to 8'h00. On the edge after the wrap, `rst_req` goes high for exactly one cycle.
- R6: While control bits [7:4] equal 4'b1010, a wrap raises no `rst_req`. Any other nibble value keeps the request enabled.
- R7: After power-on the counter runs at ratio 00, whatever the select bits hold. `cpu_clk_en` rises 128*2^LOG_D0+1 cycles after reset release.
- R8: When `stop_mode` is high in running state, `cpu_clk_en` drops on the next edge. From then on the counter and prescaler hold their values and no `rst_req` is raised.
- R9: When `ext_wake` is high in the stopped state, the counter and prescaler are zeroed and the timer runs at the selected ratio. `cpu_clk_en` rises 128*ratio+1 cycles after the wake edge. `ext_wake` has no effect outside the stopped state.
- R10: No `rst_req` is raised during a stabilization period. The counter is zero when `cpu_clk_en` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read data |
| stop_mode | input | 1 | High while the chip enters Stop mode |
| ext_wake | input | 1 | External interrupt wake request |
| rst_req | output | 1 | One-cycle system reset request |
| cpu_clk_en | output | 1 | CPU clock enable |

## Verification
The bench covers each of the four prescaler ratios with windows placed just short of the wrap and just past it. A wrong divide ratio or a late wrap shows up as a missing or an early reset pulse. The bench writes a fast select during the power-on settling period. A design that obeyed that select would raise the CPU enable about eight times too early. The bench then waits in Stop mode for longer than a full wrap period, which catches a counter that keeps running. Finally it counts reset pulses right after each settling period ends. A design that left the counter at 128 would fire the watchdog after half a period.

// File: rtl/wdt_stab_timer.sv
module wdt_stab_timer #(
  parameter int          CNT_W   = 8,
  parameter int          LOG_D0  = 12,
  parameter int          LOG_D1  = 10,
  parameter int          LOG_D2  = 7,
  parameter int          LOG_D3  = 4,
  parameter logic [3:0]  OFF_KEY = 4'b1010
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       stop_mode,
  input  logic       ext_wake,
  output logic       rst_req,
  output logic       cpu_clk_en
);
  localparam int M01   = (LOG_D0 > LOG_D1) ? LOG_D0 : LOG_D1;
  localparam int M23   = (LOG_D2 > LOG_D3) ? LOG_D2 : LOG_D3;
  localparam int PRE_W = (M01 > M23) ? M01 : M23;
  localparam logic [PRE_W-1:0] MSK0 = PRE_W'((64'd1 << LOG_D0) - 64'd1);
  localparam logic [PRE_W-1:0] MSK1 = PRE_W'((64'd1 << LOG_D1) - 64'd1);
  localparam logic [PRE_W-1:0] MSK2 = PRE_W'((64'd1 << LOG_D2) - 64'd1);
  localparam logic [PRE_W-1:0] MSK3 = PRE_W'((64'd1 << LOG_D3) - 64'd1);

  typedef enum logic [1:0] {S_RUN, S_STOP, S_STAB} st_t;

  st_t              st;
  logic [3:0]       key;
  logic [1:0]       sel;
  logic             from_por;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] msk;
  logic             rst_q;

  wire       clr_stb = ctl_we & ctl_wdata[1];
  wire       wake    = (st == S_STOP) & ext_wake;
  wire [1:0] eff_sel = (st == S_STAB && from_por) ? 2'b00 : sel;
  wire       tick    = (st != S_STOP) && ((pre & msk) == msk);
  wire       done    = (st == S_STAB) && cnt[CNT_W-1];
  wire       ovf     = (st == S_RUN) && tick && (&cnt);

  always_comb
    case (eff_sel)
      2'b00:   msk = MSK0;
      2'b01:   msk = MSK1;
      2'b10:   msk = MSK2;
      default: msk = MSK3;
    endcase

  assign ctl_rdata  = {key, sel, 2'b00};
  assign rst_req    = rst_q;
  assign cpu_clk_en = (st == S_RUN);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      key <= '0;
      sel <= '0;
    end else if (ctl_we) begin
      key <= ctl_wdata[7:4];
      sel <= ctl_wdata[3:2];
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      st       <= S_STAB;
      from_por <= 1'b1;
    end else
      case (st)
        S_RUN:   if (stop_mode) st <= S_STOP;
        S_STOP:  if (ext_wake) begin st <= S_STAB; from_por <= 1'b0; end
        default: if (cnt[CNT_W-1]) st <= S_RUN;
      endcase

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)              pre <= '0;
    else if (wake)           pre <= '0;
    else if (st != S_STOP)   pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                      cnt <= '0;
    else if (wake || done || clr_stb) cnt <= '0;
    else if (tick)                   cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) rst_q <= 1'b0;
    else        rst_q <= ovf && (key != OFF_KEY);

  // R5
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> !rst_req);

  // R6
  key_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    (key == OFF_KEY) |=> !rst_req);

  // R8
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_STOP && !ext_wake && !clr_stb) |=> ($stable(cnt) && $stable(pre)));

  // R8
  stop_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_clk_en && stop_mode) |=> !cpu_clk_en);

  // R10
  stab_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st != S_RUN) |=> !rst_req);

  // R10
  en_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cpu_clk_en) |-> ($past(cnt[CNT_W-1]) && cnt == '0));
endmodule

// File: tb/wdt_stab_timer_tb.sv
`timescale 1ns/1ps
module wdt_stab_timer_tb;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       stop_mode = 1'b0;
  logic       ext_wake = 1'b0;
  logic       rst_req;
  logic       cpu_clk_en;

  int checks = 0, errors = 0, pulses = 0, width_err = 0, cyc = 0;
  logic prev_req = 1'b0;

  always #2.5 clk = ~clk;

  wdt_stab_timer #(.LOG_D0(4), .LOG_D1(3), .LOG_D2(2), .LOG_D3(1)) u_dut (
    .clk(clk), .por_n(por_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .stop_mode(stop_mode), .ext_wake(ext_wake),
    .rst_req(rst_req), .cpu_clk_en(cpu_clk_en));

  always @(posedge clk) cyc <= por_n ? cyc + 1 : 0;

  always @(negedge clk) begin
    if (por_n && rst_req) begin
      pulses = pulses + 1;
      if (prev_req) width_err = width_err + 1;
    end
    prev_req = rst_req;
  end

  // {ctl byte, wait edges, expected pulses}; ratios /16 /8 /4 /2 for sel 00..11
  localparam logic [31:0] VEC [0:8] = '{
    {8'h0E, 16'd508,  8'd0}, {8'h0E, 16'd516,  8'd1},
    {8'hAE, 16'd600,  8'd0}, {8'h5E, 16'd516,  8'd1},
    {8'h0A, 16'd1016, 8'd0}, {8'h0A, 16'd1030, 8'd1},
    {8'h06, 16'd2030, 8'd0}, {8'h06, 16'd2060, 8'd1},
    {8'hA2, 16'd4200, 8'd0}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    chk("R1 ctl", ctl_rdata, 0);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 cpu_clk_en", cpu_clk_en, 0);
    wr(8'h0F);
    chk("R2 readback", ctl_rdata, 8'h0C);
    wait_cyc(2046);
    chk("R7 still gated at select 11", cpu_clk_en, 0);
    wait_cyc(2051);
    chk("R7 enabled after /16 interval", cpu_clk_en, 1);
    p0 = pulses;
    repeat (500) @(negedge clk);
    chk("R10 counter cleared at exit", pulses - p0, 0);

    foreach (VEC[i]) begin
      wr(VEC[i][31:24]);
      p0 = pulses;
      repeat (int'(VEC[i][23:8])) @(negedge clk);
      chk($sformatf("R3 R4 R5 R6 vector %0d", i), pulses - p0, int'(VEC[i][7:0]));
    end

    wr(8'h0E);
    stop_mode = 1'b1;
    p0 = pulses;
    repeat (2000) @(negedge clk);
    chk("R8 gated in stop", cpu_clk_en, 0);
    chk("R8 frozen, no reset", pulses - p0, 0);
    ext_wake = 1'b1; stop_mode = 1'b0;
    @(negedge clk); ext_wake = 1'b0;
    p0 = pulses;
    repeat (252) @(negedge clk);
    chk("R9 gated during wake interval", cpu_clk_en, 0);
    repeat (6) @(negedge clk);
    chk("R9 enabled after /2 interval", cpu_clk_en, 1);
    chk("R10 no reset in interval", pulses - p0, 0);
    ext_wake = 1'b1;
    @(negedge clk); ext_wake = 1'b0;
    @(negedge clk);
    chk("R9 wake ignored in run", cpu_clk_en, 1);
    repeat (498) @(negedge clk);
    chk("R10 counter cleared at wake exit", pulses - p0, 0);
    chk("R5 single-cycle pulses", width_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule